// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Checker

This block sits on the command side of a two-bank synchronous DRAM interface and watches every rising clock edge. It decodes the chip-select, row strobe, column strobe, write enable, clock enable, precharge-select address bit and bank-select address bit into a command. It keeps a small state model for each bank: deactivated, activated, or closing on its own after a read or write with automatic deactivation. Beside the state model it keeps a set of down-counting gap timers. Each timer holds the number of cycles that must still pass after an earlier command.

A command is illegal when the bank state forbids it or when a gap timer has not yet run out. On the first illegal command the checker raises a sticky error flag and latches a numeric code for that violation. An illegal command is not applied to the state model. All minimum spacings are parameters counted in clock cycles, and so is the burst length used for write recovery and automatic closing. Data pins and refresh-interval checking are not part of the block.

Top module: `sdram_cmd_checker`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `err_o` is 0 and `err_code_o` is 0.
- R2: With chip select low and clock enable high on the previous edge, the pins {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 001 refresh, 110 burst stop, 111 no-op. `bank_sel` high addresses bank T (index 1) and `bank_sel` low addresses bank B (index 0).
- R3: An activate to a bank that is not deactivated sets error code 1.
- R4: A read or write to a bank that is not activated sets error code 2. A bank that is still closing counts as not activated.
- R5: A mode set or refresh while either bank is not deactivated sets code 3. Refreshes need no precharge between them.
- R6: A read or write fewer than T_RCD cycles after the activate of that bank sets code 4.
- R7: A precharge that hits an activated bank fewer than T_RAS cycles after its activate sets code 5. Such a precharge fewer than T_WR cycles after the final write data sets code 10. The final write data falls BURST_LEN-1 cycles after the write command.
- R8: An activate fewer than T_RC cycles after the previous activate of the same bank sets code 6. An activate, mode set or refresh fewer than T_RC cycles after a refresh sets code 11.
- R9: A precharge with `a10` low deactivates only the selected bank; with `a10` high it deactivates both banks. An activate of a bank fewer than T_RP cycles after its deactivation sets code 7. So does a mode set or refresh fewer than T_RP cycles after the deactivation of either bank.
- R10: An activate fewer than T_RRD cycles after an activate of the other bank sets code 8.
- R11: An activate, mode set or refresh fewer than T_MRD cycles after a mode set sets code 9.
- R12: A read or write with `a10` high leaves the bank closing. The bank becomes deactivated BURST_LEN cycles after a read, or BURST_LEN+T_WR cycles after a write, and its T_RP spacing starts then.
- R13: A command is ignored when chip select is high, or when `cke` was low on the previous edge.
- R14: The error flag and code hold the first violation until reset. If one command breaks several rules at once, the lowest code is latched. An illegal command does not change the bank states or the timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Precharge-all / automatic-deactivate select |
| bank_sel | input | 1 | Bank select, 1 = bank T, 0 = bank B |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 4 | Code of the first violation, 0 when none |

## Verification
The block's only outputs are the sticky flag and the code, so a bank state or gap timer that is wrong stays hidden until a later command depends on it. The fault then shows as a missing code or a wrong code one cycle after that command's edge. Each scenario therefore follows a state change with a probing command placed exactly one cycle before and exactly at the legal spacing. Scenarios also probe with commands that the rules should ignore. Because the flag is sticky, every scenario starts from reset so that each probe is seen on its own.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  localparam int ERR_W   = 4;
  localparam int NUM_ERR = 11;

  // violation codes, lower value wins when several fire together
  localparam int E_ACT_BUSY = 1;
  localparam int E_ACC_IDLE = 2;
  localparam int E_GLB_BUSY = 3;
  localparam int E_RCD      = 4;
  localparam int E_RAS      = 5;
  localparam int E_RC       = 6;
  localparam int E_RP       = 7;
  localparam int E_RRD      = 8;
  localparam int E_MRD      = 9;
  localparam int E_WR       = 10;
  localparam int E_RFC      = 11;

  typedef enum logic [3:0] {
    CMD_IGN, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
    CMD_PRE, CMD_MRS, CMD_REF, CMD_STOP
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_CLOSING = 2'd2
  } bank_st_e;

  typedef struct packed {
    cmd_e op;
    logic a10;
    logic bank;
  } cmd_t;

  // value loaded into a gap timer so that a command k edges later is legal iff k >= t
  function automatic int gap_load(input int t);
    return (t > 0) ? t - 1 : 0;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          clear_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load_i)
      cnt_d = val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign clear_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  logic bank_sel,
  output cmd_t cmd_o
);

  logic cke_q, cke_d;

  always_comb cke_d = cke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cke_q <= 1'b1;
    else
      cke_q <= cke_d;
  end

  always_comb begin
    cmd_o.a10  = a10;
    cmd_o.bank = bank_sel;
    if (!cke_q || cs_n) begin
      cmd_o.op = CMD_IGN;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd_o.op = CMD_ACT;
        3'b101:  cmd_o.op = CMD_RD;
        3'b100:  cmd_o.op = CMD_WR;
        3'b010:  cmd_o.op = CMD_PRE;
        3'b000:  cmd_o.op = CMD_MRS;
        3'b001:  cmd_o.op = CMD_REF;
        3'b110:  cmd_o.op = CMD_STOP;
        default: cmd_o.op = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_chk_pkg::*;
#(
  parameter int CW        = 3,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RC      = 6,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 1,
  parameter int BURST_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_i,
  input  logic     acc_i,
  input  logic     wr_i,
  input  logic     auto_i,
  input  logic     pre_i,
  output bank_st_e st_o,
  output logic     rcd_ok_o,
  output logic     ras_ok_o,
  output logic     rc_ok_o,
  output logic     rp_ok_o,
  output logic     rrd_ok_o,
  output logic     wr_ok_o
);

  localparam int L_RCD  = gap_load(T_RCD);
  localparam int L_RAS  = gap_load(T_RAS);
  localparam int L_RC   = gap_load(T_RC);
  localparam int L_RP   = gap_load(T_RP);
  localparam int L_RRD  = gap_load(T_RRD);
  localparam int L_WREC = gap_load(BURST_LEN - 1 + T_WR);
  localparam int L_CLR  = BURST_LEN - 1;
  localparam int L_CLW  = BURST_LEN - 1 + T_WR;

  bank_st_e      st_q, st_d;
  logic          close_ld, close_done, rp_ld, wrec_ld;
  logic [CW-1:0] close_val;

  always_comb begin
    close_ld  = acc_i && auto_i && (st_q == BK_OPEN);
    wrec_ld   = acc_i && wr_i;
    close_val = wr_i ? CW'(L_CLW) : CW'(L_CLR);
  end

  always_comb begin
    st_d  = st_q;
    rp_ld = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (act_i) st_d = BK_OPEN;
      end
      BK_OPEN: begin
        if (pre_i) begin
          st_d  = BK_IDLE;
          rp_ld = 1'b1;
        end else if (close_ld) begin
          st_d = BK_CLOSING;
        end
      end
      BK_CLOSING: begin
        if (close_done) begin
          st_d  = BK_IDLE;
          rp_ld = 1'b1;
        end
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= BK_IDLE;
    else
      st_q <= st_d;
  end

  assign st_o = st_q;

  sdram_gap_timer #(.CW(CW)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(L_RCD)), .clear_o(rcd_ok_o));
  sdram_gap_timer #(.CW(CW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(L_RAS)), .clear_o(ras_ok_o));
  sdram_gap_timer #(.CW(CW)) u_rc (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(L_RC)), .clear_o(rc_ok_o));
  sdram_gap_timer #(.CW(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load_i(act_i), .val_i(CW'(L_RRD)), .clear_o(rrd_ok_o));
  sdram_gap_timer #(.CW(CW)) u_rp (
    .clk(clk), .rst_n(rst_n), .load_i(rp_ld), .val_i(CW'(L_RP)), .clear_o(rp_ok_o));
  sdram_gap_timer #(.CW(CW)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load_i(wrec_ld), .val_i(CW'(L_WREC)), .clear_o(wr_ok_o));
  sdram_gap_timer #(.CW(CW)) u_close (
    .clk(clk), .rst_n(rst_n), .load_i(close_ld), .val_i(close_val), .clear_o(close_done));

endmodule

// File: rtl/sdram_err_latch.sv
module sdram_err_latch #(
  parameter int NV     = 11,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NV:1]       viol_i,
  output logic              err_o,
  output logic [CODE_W-1:0] code_o
);

  logic              err_q, err_d;
  logic [CODE_W-1:0] code_q, code_d, pick;

  always_comb begin
    pick = '0;
    for (int i = NV; i >= 1; i--) begin
      if (viol_i[i]) pick = CODE_W'(i);
    end
  end

  always_comb begin
    err_d  = err_q | (|viol_i);
    code_d = err_q ? code_q : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= '0;
    end else begin
      err_q  <= err_d;
      code_q <= code_d;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_RC      = 6,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 1,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             a10,
  input  logic             bank_sel,
  output logic             err_o,
  output logic [ERR_W-1:0] err_code_o
);

  localparam int NB     = 2;
  localparam int MAXGAP = imax(imax(imax(T_RC, T_RAS), imax(BURST_LEN + T_WR, T_MRD)),
                               imax(imax(T_RCD, T_RP), T_RRD));
  localparam int CW     = $clog2(MAXGAP + 1);

  cmd_t            cmd;
  bank_st_e        st [NB];
  logic [2*NB-1:0] st_flat;
  logic [NB-1:0]   rcd_ok, ras_ok, rc_ok, rp_ok, rrd_ok, wr_ok;
  logic [NB-1:0]   act_s, acc_s, pre_s;
  logic            mrd_ok, rfc_ok, accept, tgt, oth, is_wr;
  logic [NUM_ERR:1] viol;

  sdram_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .bank_sel(bank_sel), .cmd_o(cmd));

  always_comb begin
    tgt   = cmd.bank;
    oth   = ~cmd.bank;
    is_wr = (cmd.op == CMD_WR);
  end

  // rule evaluation for the decoded command
  always_comb begin
    viol = '0;
    case (cmd.op)
      CMD_ACT: begin
        if (st[tgt] != BK_IDLE) viol[E_ACT_BUSY] = 1'b1;
        if (!rc_ok[tgt])        viol[E_RC]       = 1'b1;
        if (!rp_ok[tgt])        viol[E_RP]       = 1'b1;
        if (!rrd_ok[oth])       viol[E_RRD]      = 1'b1;
        if (!mrd_ok)            viol[E_MRD]      = 1'b1;
        if (!rfc_ok)            viol[E_RFC]      = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (st[tgt] != BK_OPEN) viol[E_ACC_IDLE] = 1'b1;
        if (!rcd_ok[tgt])       viol[E_RCD]      = 1'b1;
      end
      CMD_PRE: begin
        for (int b = 0; b < NB; b++) begin
          if ((cmd.a10 || (cmd.bank == 1'(b))) && (st[b] == BK_OPEN)) begin
            if (!ras_ok[b]) viol[E_RAS] = 1'b1;
            if (!wr_ok[b])  viol[E_WR]  = 1'b1;
          end
        end
      end
      CMD_MRS, CMD_REF: begin
        for (int b = 0; b < NB; b++) begin
          if (st[b] != BK_IDLE) viol[E_GLB_BUSY] = 1'b1;
          if (!rp_ok[b])        viol[E_RP]       = 1'b1;
        end
        if (!mrd_ok) viol[E_MRD] = 1'b1;
        if (!rfc_ok) viol[E_RFC] = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb accept = (cmd.op != CMD_IGN) && (viol == '0);

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      always_comb begin
        act_s[b] = accept && (cmd.op == CMD_ACT) && (cmd.bank == 1'(b));
        acc_s[b] = accept && ((cmd.op == CMD_RD) || (cmd.op == CMD_WR)) && (cmd.bank == 1'(b));
        pre_s[b] = accept && (cmd.op == CMD_PRE) && (cmd.a10 || (cmd.bank == 1'(b)));
      end

      sdram_bank_track #(
        .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
        .T_RRD(T_RRD), .T_WR(T_WR), .BURST_LEN(BURST_LEN)
      ) u_trk (
        .clk(clk), .rst_n(rst_n), .act_i(act_s[b]), .acc_i(acc_s[b]),
        .wr_i(is_wr), .auto_i(cmd.a10), .pre_i(pre_s[b]), .st_o(st[b]),
        .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]), .rc_ok_o(rc_ok[b]),
        .rp_ok_o(rp_ok[b]), .rrd_ok_o(rrd_ok[b]), .wr_ok_o(wr_ok[b]));

      assign st_flat[2*b +: 2] = st[b];
    end
  endgenerate

  sdram_gap_timer #(.CW(CW)) u_mrd (
    .clk(clk), .rst_n(rst_n), .load_i(accept && (cmd.op == CMD_MRS)),
    .val_i(CW'(gap_load(T_MRD))), .clear_o(mrd_ok));

  sdram_gap_timer #(.CW(CW)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load_i(accept && (cmd.op == CMD_REF)),
    .val_i(CW'(gap_load(T_RC))), .clear_o(rfc_ok));

  sdram_err_latch #(.NV(NUM_ERR), .CODE_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .viol_i(viol), .err_o(err_o), .code_o(err_code_o));

endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       bank_sel,
  input logic       err_o,
  input logic [3:0] err_code_o,
  input logic [3:0] st_flat
);

  logic [2:0] pins;
  logic [1:0] tgt_st;
  logic       sel, is_act, is_acc, is_glb, any_busy;

  always_comb begin
    pins     = {ras_n, cas_n, we_n};
    sel      = !cs_n;
    is_act   = sel && (pins == 3'b011);
    is_acc   = sel && ((pins == 3'b101) || (pins == 3'b100));
    is_glb   = sel && ((pins == 3'b000) || (pins == 3'b001));
    tgt_st   = bank_sel ? st_flat[3:2] : st_flat[1:0];
    any_busy = (st_flat[3:2] != 2'd0) || (st_flat[1:0] != 2'd0);
  end

  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!err_o && (err_code_o == 4'd0)));

  a_r3_act_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && is_act && (tgt_st != 2'd0) && !err_o) |=> (err_o && (err_code_o == 4'd1)));

  a_r4_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && is_acc && (tgt_st != 2'd1) && !err_o) |=> (err_o && (err_code_o == 4'd2)));

  a_r5_global_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && is_glb && any_busy && !err_o) |=> (err_o && (err_code_o == 4'd3)));

  a_r13_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !err_o) |=> !err_o);

  a_r13_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cke) && !err_o) |=> !err_o);

  a_r14_sticky_code: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(err_code_o)));

endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .err_o(err_o),
  .err_code_o(err_code_o), .st_flat(st_flat));

// File: tb/sdram_cmd_checker_tb_top.sv
module sdram_cmd_checker_tb_top;

  logic       clk;
  logic       rst_n;
  logic       cke, cs_n, ras_n, cas_n, we_n, a10, bank_sel;
  logic       err_o;
  logic [3:0] err_code_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [2:0] P_ACT = 3'b011;
  localparam logic [2:0] P_RD  = 3'b101;
  localparam logic [2:0] P_WR  = 3'b100;
  localparam logic [2:0] P_PRE = 3'b010;
  localparam logic [2:0] P_MRS = 3'b000;
  localparam logic [2:0] P_REF = 3'b001;
  localparam logic [2:0] P_NOP = 3'b111;

  sdram_cmd_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .bank_sel(bank_sel),
    .err_o(err_o), .err_code_o(err_code_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic set_pins(input logic [2:0] p, input logic a, input logic b);
    {ras_n, cas_n, we_n} = p;
    a10      = a;
    bank_sel = b;
  endtask

  // one command occupies one cycle; returns at the negedge after its edge
  task automatic issue(input logic [2:0] p, input logic a, input logic b);
    cs_n = 1'b0;
    set_pins(p, a, b);
    @(negedge clk);
    set_pins(P_NOP, 1'b0, 1'b0);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cke   = 1'b1;
    cs_n  = 1'b0;
    set_pins(P_NOP, 1'b0, 1'b0);
    nops(2);
    rst_n = 1'b1;
    nops(1);
  endtask

  task automatic check(input string req, input logic e_err, input logic [3:0] e_code);
    n_chk++;
    if (err_o !== e_err || err_code_o !== e_code) begin
      n_fail++;
      $display("FAIL %s: err=%0b code=%0d expected err=%0b code=%0d",
               req, err_o, err_code_o, e_err, e_code);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b0; set_pins(P_NOP, 1'b0, 1'b0);
    nops(1);
    check("R1 during reset", 1'b0, 4'd0);
    rst_n = 1'b1;
    nops(1);
    check("R1 after reset", 1'b0, 4'd0);
  endtask

  task automatic t_legal_flow();
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_ACT, 0, 1); nops(1);
    issue(P_RD, 0, 0);
    issue(P_WR, 0, 1); nops(3);
    issue(P_PRE, 1, 0); nops(1);
    issue(P_MRS, 0, 0); nops(1);
    issue(P_REF, 0, 0); nops(5);
    check("R2 R9 legal flow before second refresh", 1'b0, 4'd0);
    issue(P_REF, 0, 0); nops(5);
    issue(P_ACT, 0, 0);
    check("R5 R8 back-to-back refresh then activate", 1'b0, 4'd0);
  endtask

  task automatic t_act_busy();
    do_reset();
    issue(P_ACT, 0, 1); nops(6);
    issue(P_ACT, 0, 1);
    check("R3 activate of open bank", 1'b1, 4'd1);
    do_reset();
    issue(P_ACT, 0, 0);
    issue(P_ACT, 0, 0);
    check("R14 lowest code wins (R3 over tRC)", 1'b1, 4'd1);
  endtask

  task automatic t_acc_idle();
    do_reset();
    issue(P_RD, 0, 0);
    check("R4 read of idle bank", 1'b1, 4'd2);
    do_reset();
    issue(P_ACT, 0, 0); nops(3);
    issue(P_WR, 0, 1);
    check("R4 R2 write to other bank", 1'b1, 4'd2);
    do_reset();
    issue(P_ACT, 0, 1); nops(3);
    issue(P_RD, 0, 1);
    check("R2 bank_sel high addresses bank T", 1'b0, 4'd0);
  endtask

  task automatic t_glb_busy();
    do_reset();
    issue(P_ACT, 0, 0); nops(6);
    issue(P_MRS, 0, 0);
    check("R5 mode set with open bank", 1'b1, 4'd3);
    do_reset();
    issue(P_ACT, 0, 1); nops(6);
    issue(P_REF, 0, 0);
    check("R5 refresh with open bank", 1'b1, 4'd3);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(P_ACT, 0, 0);
    issue(P_RD, 0, 0);
    check("R6 read one cycle after activate", 1'b1, 4'd4);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 0, 0);
    check("R6 read at spacing", 1'b0, 4'd0);
  endtask

  task automatic t_ras_wr();
    do_reset();
    issue(P_ACT, 0, 0); nops(2);
    issue(P_PRE, 0, 0);
    check("R7 precharge before tRAS", 1'b1, 4'd5);
    do_reset();
    issue(P_ACT, 0, 0); nops(3);
    issue(P_PRE, 0, 0);
    check("R7 precharge at tRAS", 1'b0, 4'd0);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_WR, 0, 0); nops(2);
    issue(P_PRE, 0, 0);
    check("R7 precharge inside write recovery", 1'b1, 4'd10);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_WR, 0, 0); nops(3);
    issue(P_PRE, 0, 0);
    check("R7 precharge after write recovery", 1'b0, 4'd0);
  endtask

  task automatic t_rc_rp();
    do_reset();
    issue(P_ACT, 0, 0); nops(3);
    issue(P_PRE, 0, 0);
    issue(P_ACT, 0, 0);
    check("R8 activate before tRC", 1'b1, 4'd6);
    do_reset();
    issue(P_ACT, 0, 0); nops(3);
    issue(P_PRE, 0, 0); nops(1);
    issue(P_ACT, 0, 0);
    check("R8 activate at tRC", 1'b0, 4'd0);
    do_reset();
    issue(P_ACT, 0, 0); nops(5);
    issue(P_PRE, 0, 0);
    issue(P_ACT, 0, 0);
    check("R9 activate before tRP", 1'b1, 4'd7);
  endtask

  task automatic t_pre_sel();
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_ACT, 0, 1); nops(3);
    issue(P_PRE, 0, 0); nops(1);
    issue(P_RD, 0, 1);
    check("R9 single precharge keeps other bank", 1'b0, 4'd0);
    issue(P_RD, 0, 0);
    check("R9 single precharge closes selected bank", 1'b1, 4'd2);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_ACT, 0, 1); nops(3);
    issue(P_PRE, 1, 0); nops(1);
    issue(P_RD, 0, 1);
    check("R9 precharge-all closes both banks", 1'b1, 4'd2);
  endtask

  task automatic t_rrd_mrd_rfc();
    do_reset();
    issue(P_ACT, 0, 0);
    issue(P_ACT, 0, 1);
    check("R10 activate other bank too soon", 1'b1, 4'd8);
    do_reset();
    issue(P_MRS, 0, 0);
    issue(P_REF, 0, 0);
    check("R11 refresh right after mode set", 1'b1, 4'd9);
    do_reset();
    issue(P_MRS, 0, 0); nops(1);
    issue(P_ACT, 0, 0);
    check("R11 activate at mode-set spacing", 1'b0, 4'd0);
    do_reset();
    issue(P_REF, 0, 0); nops(2);
    issue(P_REF, 0, 0);
    check("R8 refresh before refresh cycle ends", 1'b1, 4'd11);
    do_reset();
    issue(P_REF, 0, 0); nops(2);
    issue(P_MRS, 0, 0);
    check("R8 mode set before refresh cycle ends", 1'b1, 4'd11);
  endtask

  task automatic t_auto();
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 1, 0);
    issue(P_RD, 0, 0);
    check("R12 read of closing bank", 1'b1, 4'd2);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 1, 0); nops(3);
    issue(P_ACT, 0, 0);
    check("R12 activate while closing", 1'b1, 4'd1);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 1, 0); nops(4);
    issue(P_ACT, 0, 0);
    check("R12 activate inside post-close tRP", 1'b1, 4'd7);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 1, 0); nops(5);
    issue(P_ACT, 0, 0);
    check("R12 activate after read auto-close", 1'b0, 4'd0);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_WR, 1, 0); nops(5);
    issue(P_ACT, 0, 0);
    check("R12 activate early after write auto-close", 1'b1, 4'd7);
    do_reset();
    issue(P_ACT, 0, 0); nops(1);
    issue(P_WR, 1, 0); nops(6);
    issue(P_ACT, 0, 0);
    check("R12 activate after write auto-close", 1'b0, 4'd0);
  endtask

  task automatic t_ignore();
    do_reset();
    cke = 1'b0; nops(1);
    cke = 1'b1;
    issue(P_ACT, 0, 0); nops(1);
    issue(P_RD, 0, 0);
    check("R13 activate ignored after low clock enable", 1'b1, 4'd2);
    do_reset();
    cke = 1'b0; nops(1);
    cke = 1'b1;
    issue(P_RD, 0, 0);
    check("R13 illegal read ignored after low clock enable", 1'b0, 4'd0);
    do_reset();
    cs_n = 1'b1; set_pins(P_ACT, 1'b0, 1'b0);
    nops(1);
    cs_n = 1'b0; set_pins(P_NOP, 1'b0, 1'b0);
    nops(1);
    check("R13 deselected activate raises nothing", 1'b0, 4'd0);
    issue(P_RD, 0, 0);
    check("R13 deselected activate left bank idle", 1'b1, 4'd2);
  endtask

  task automatic t_sticky();
    do_reset();
    issue(P_RD, 0, 1);
    issue(P_MRS, 0, 0);
    issue(P_ACT, 0, 0);
    issue(P_ACT, 0, 0);
    nops(2);
    check("R14 first code held", 1'b1, 4'd2);
  endtask

  initial begin
    t_reset();
    t_legal_flow();
    t_act_busy();
    t_acc_idle();
    t_glb_busy();
    t_rcd();
    t_ras_wr();
    t_rc_rp();
    t_pre_sel();
    t_rrd_mrd_rfc();
    t_auto();
    t_ignore();
    t_sticky();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule